// File: doc/BRIEF.md
# Shared-Port Read Data Lane Enable

This block computes which of the eight host data bus bits the controller may drive while the host reads through one of the controller's I/O windows. Two devices can answer one port address. The usual case is the drive-control port, where a floppy controller supplies the top bit and a hard disk supplies the lower seven. Each window carries a small lane mode. On an I/O read of either shared drive port, that mode can hold back the top bit or the lower seven bits, so that the other device can drive them without contention.

The lane modes are written through an indexed pair of host I/O ports. One port holds an 8-bit index. The other port reads or writes the register that the index currently selects. The data bus lane enables are combinational from the read strobe and the window hit, so they drop in the same clock in which the strobe is released. Window base/limit matching and the card-side data path belong to other blocks; this block receives only the hit, the window number and whether the hit window is an I/O window.

Top module: `rdmask_ctrl`

## Requirements
- R1: After reset every window's lane mode is 00 and the index register reads 0x00.
- R2: A host read of the index port (default 0x0310) returns the stored index. A host write to that port takes effect for the very next data-port access.
- R3: The data port (default 0x0311) accesses the lane mode of window w at index 0x40+w, with the mode in bits 1:0 and bits 7:2 reading 0. Indices outside that range read 0x00, and writes to them change no mode.
- R4: Lane mode 00 on an I/O window read of a shared port gives data_oe = 0xFF.
- R5: Lane mode 01 on an I/O window read of address 0x3F7 or 0x377 gives data_oe = 0x7F, so bit 7 is left to the other device.
- R6: Lane mode 10 on an I/O window read of address 0x3F7 or 0x377 gives data_oe = 0x80, so only bit 7 is driven.
- R7: Lane mode 11 is reserved and behaves as 00, giving data_oe = 0xFF.
- R8: An I/O window read at any address other than the two shared ports gives data_oe = 0xFF, whatever the mode.
- R9: A memory window read (win_is_io = 0) gives data_oe = 0xFF, whatever the mode.
- R10: data_oe is 0x00 whenever host_ior or win_hit is low, including during host writes. It falls in the same cycle in which the strobe is released.
- R11: The mode applied is that of the window named by win_num. Windows are programmed and applied independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 16 | Host I/O address |
| host_ior | input | 1 | Host I/O read strobe, active high |
| host_iow | input | 1 | Host I/O write strobe, active high, sampled at the clock edge |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read data for the index and data ports |
| reg_rd_hit | output | 1 | High while the host reads the index or data port |
| win_hit | input | 1 | A window matched the current host access |
| win_is_io | input | 1 | The matched window is an I/O window |
| win_num | input | 2 | Number of the matched window |
| data_oe | output | 8 | Per-bit drive enable for the host data bus |

## Verification
The assertions assume that host_ior and host_iow are never high together, that the window inputs are steady while the read strobe is high, and that win_num names an existing window whenever win_hit is high. The bench changes every input only on the falling clock edge and raises one strobe at a time. It holds the window number and address constant for the whole read. It samples data_oe one time unit after the inputs settle, and again after the strobe drops, without waiting for a clock edge.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    LANE_ALL  = 2'b00,
    LANE_LOW  = 2'b01,
    LANE_TOP  = 2'b10,
    LANE_RSVD = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/rdm_port_match.sv
module rdm_port_match #(
  parameter int          ADDR_W = 16,
  parameter int          NUM_PORTS = 2,
  parameter logic [ADDR_W*NUM_PORTS-1:0] PORT_LIST = {16'h0377, 16'h03F7}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              shared_hit
);
  logic [NUM_PORTS-1:0] port_eq;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_eq[p] = (addr == PORT_LIST[p*ADDR_W +: ADDR_W]);
  end

  assign shared_hit = |port_eq;
endmodule

// File: rtl/rdm_index_regs.sv
module rdm_index_regs
  import rdm_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          NUM_WIN   = 4,
  parameter logic [ADDR_W-1:0] IDX_ADDR  = 16'h0310,
  parameter logic [ADDR_W-1:0] DAT_ADDR  = 16'h0311,
  parameter logic [DATA_W-1:0] MASK_BASE = 8'h40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic                     host_ior,
  input  logic                     host_iow,
  input  logic [DATA_W-1:0]        host_wdata,
  output logic [DATA_W-1:0]        host_rdata,
  output logic                     reg_rd_hit,
  output logic [NUM_WIN*MODE_W-1:0] mode_flat
);
  localparam int PAD_W = DATA_W - MODE_W;

  logic [DATA_W-1:0] index_q;
  logic [DATA_W-1:0] offset;
  logic              idx_sel, dat_sel, in_range;
  logic              dat_wr, idx_wr;
  logic [NUM_WIN-1:0] slot_hit;
  logic [MODE_W-1:0]  sel_mode;
  logic               unused_wdata_hi;

  assign idx_sel  = (host_addr == IDX_ADDR);
  assign dat_sel  = (host_addr == DAT_ADDR);
  assign idx_wr   = host_iow && idx_sel;
  assign dat_wr   = host_iow && dat_sel;
  assign offset   = index_q - MASK_BASE;
  assign in_range = (index_q >= MASK_BASE) && (offset < DATA_W'(NUM_WIN));
  assign unused_wdata_hi = ^host_wdata[DATA_W-1:MODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      index_q <= '0;
    else if (idx_wr) index_q <= host_wdata;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [MODE_W-1:0] mode_q;
    assign slot_hit[w] = in_range && (offset == DATA_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mode_q <= LANE_ALL;
      else if (dat_wr && slot_hit[w])  mode_q <= host_wdata[MODE_W-1:0];
    end
    assign mode_flat[w*MODE_W +: MODE_W] = mode_q;
  end

  always_comb begin
    sel_mode = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (slot_hit[w]) sel_mode = mode_flat[w*MODE_W +: MODE_W];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_ior && idx_sel)      host_rdata = index_q;
    else if (host_ior && dat_sel) host_rdata = {{PAD_W{1'b0}}, sel_mode};
  end

  assign reg_rd_hit = host_ior && (idx_sel || dat_sel);

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> index_q == $past(host_wdata));  // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(mode_flat));  // R3
  AST_RANGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !in_range) |=> $stable(mode_flat));  // R3
  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));  // R11
endmodule

// File: rtl/rdm_lane_mask.sv
module rdm_lane_mask
  import rdm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_WIN = 4,
  parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_ior,
  input  logic                      win_hit,
  input  logic                      win_is_io,
  input  logic [WIN_W-1:0]          win_num,
  input  logic                      shared_hit,
  input  logic [NUM_WIN*MODE_W-1:0] mode_flat,
  output logic [DATA_W-1:0]         data_oe
);
  localparam logic [DATA_W-1:0] ALL_ON  = '1;
  localparam logic [DATA_W-1:0] TOP_ON  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] LOW_ON  = ~TOP_ON;

  lane_mode_e         cur_mode;
  logic               rd_active;
  logic [DATA_W-1:0]  lane_sel;

  always_comb begin
    cur_mode = LANE_ALL;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win_num == WIN_W'(w)) cur_mode = lane_mode_e'(mode_flat[w*MODE_W +: MODE_W]);
    end
  end

  always_comb begin
    unique case (cur_mode)
      LANE_LOW: lane_sel = LOW_ON;
      LANE_TOP: lane_sel = TOP_ON;
      default:  lane_sel = ALL_ON;
    endcase
  end

  assign rd_active = host_ior && win_hit;

  always_comb begin
    if (!rd_active)                    data_oe = '0;
    else if (win_is_io && shared_hit)  data_oe = lane_sel;
    else                               data_oe = ALL_ON;
  end

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ior && win_hit) |-> data_oe == '0);  // R10
  AST_MEM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ior && win_hit && !win_is_io) |-> data_oe == ALL_ON);  // R9
  AST_OFFPORT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ior && win_hit && !shared_hit) |-> data_oe == ALL_ON);  // R8
  AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ior && win_hit) |-> (data_oe == ALL_ON || data_oe == LOW_ON || data_oe == TOP_ON));  // R5
  AST_FALL_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_ior) |-> data_oe == '0);  // R10
endmodule

// File: rtl/rdmask_ctrl.sv
module rdmask_ctrl
  import rdm_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          NUM_WIN   = 4,
  parameter logic [ADDR_W-1:0] IDX_ADDR  = 16'h0310,
  parameter logic [ADDR_W-1:0] DAT_ADDR  = 16'h0311,
  parameter logic [DATA_W-1:0] MASK_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] SHARED_A  = 16'h03F7,
  parameter logic [ADDR_W-1:0] SHARED_B  = 16'h0377,
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_ior,
  input  logic              host_iow,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              reg_rd_hit,
  input  logic              win_hit,
  input  logic              win_is_io,
  input  logic [WIN_W-1:0]  win_num,
  output logic [DATA_W-1:0] data_oe
);
  logic [NUM_WIN*MODE_W-1:0] mode_flat;
  logic                      shared_hit;

  rdm_index_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN),
    .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR), .MASK_BASE(MASK_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
    .host_ior(host_ior), .host_iow(host_iow), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .reg_rd_hit(reg_rd_hit), .mode_flat(mode_flat)
  );

  rdm_port_match #(
    .ADDR_W(ADDR_W), .NUM_PORTS(2), .PORT_LIST({SHARED_B, SHARED_A})
  ) u_match (
    .addr(host_addr), .shared_hit(shared_hit)
  );

  rdm_lane_mask #(
    .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .WIN_W(WIN_W)
  ) u_lane (
    .clk(clk), .rst_n(rst_n), .host_ior(host_ior), .win_hit(win_hit),
    .win_is_io(win_is_io), .win_num(win_num), .shared_hit(shared_hit),
    .mode_flat(mode_flat), .data_oe(data_oe)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ior && host_iow));  // R10
endmodule

// File: tb/rdmask_ctrl_test.sv
module rdmask_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDX = 16'h0310;
  localparam logic [15:0] DAT = 16'h0311;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] host_addr = '0;
  logic        host_ior = 0, host_iow = 0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        reg_rd_hit;
  logic        win_hit = 0, win_is_io = 0;
  logic [1:0]  win_num = '0;
  logic [7:0]  data_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdmask_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_ior(host_ior),
    .host_iow(host_iow), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_rd_hit(reg_rd_hit), .win_hit(win_hit), .win_is_io(win_is_io),
    .win_num(win_num), .data_oe(data_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_iow = 1;
    @(negedge clk);
    host_iow = 0; host_addr = '0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_ior = 1;
    #1 d = host_rdata;
    @(negedge clk);
    host_ior = 0; host_addr = '0;
  endtask

  task automatic set_mode(input int w, input logic [1:0] m);
    io_write(IDX, 8'h40 + 8'(w));
    io_write(DAT, {6'b0, m});
  endtask

  task automatic win_read(input string req, input logic [15:0] a, input int w,
                          input logic io, input logic [7:0] exp);
    @(negedge clk);
    host_addr = a; win_num = 2'(w); win_is_io = io; win_hit = 1; host_ior = 1;
    #1 check(req, data_oe, exp);
    @(negedge clk);
    check(req, data_oe, exp);
    host_ior = 0;
    #1 check("R10 strobe release", data_oe, 8'h00);
    win_hit = 0; host_addr = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    io_read(IDX, d); check("R1 index reset", d, 8'h00);
    for (int w = 0; w < 4; w++) begin
      io_write(IDX, 8'h40 + 8'(w));
      io_read(DAT, d); check("R1 mode reset", d, 8'h00);
    end
    win_read("R4 default full drive", 16'h03F7, 0, 1, 8'hFF);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    io_write(IDX, 8'h41);
    io_read(IDX, d); check("R2 index readback", d, 8'h41);
    io_write(DAT, 8'hFE);
    io_read(DAT, d); check("R3 upper bits read zero", d, 8'h02);
    io_write(IDX, 8'h42);
    io_read(DAT, d); check("R2 new index next access", d, 8'h00);
    io_write(IDX, 8'h44);
    io_write(DAT, 8'h03);
    io_read(DAT, d); check("R3 out of range reads zero", d, 8'h00);
    io_write(IDX, 8'h3F);
    io_write(DAT, 8'h01);
    for (int w = 0; w < 4; w++) begin
      io_write(IDX, 8'h40 + 8'(w));
      io_read(DAT, d);
      check("R3 out of range write ignored", d, (w == 1) ? 8'h02 : 8'h00);
    end
    set_mode(1, 2'b00);
  endtask

  task automatic t_modes;
    set_mode(0, 2'b01);
    win_read("R5 low seven at 3F7", 16'h03F7, 0, 1, 8'h7F);
    win_read("R5 low seven at 377", 16'h0377, 0, 1, 8'h7F);
    set_mode(0, 2'b10);
    win_read("R6 top only at 3F7", 16'h03F7, 0, 1, 8'h80);
    win_read("R6 top only at 377", 16'h0377, 0, 1, 8'h80);
    set_mode(0, 2'b11);
    win_read("R7 reserved full", 16'h03F7, 0, 1, 8'hFF);
    set_mode(0, 2'b00);
    win_read("R4 mode 00 at 377", 16'h0377, 0, 1, 8'hFF);
  endtask

  task automatic t_other;
    set_mode(2, 2'b01);
    win_read("R8 other address full", 16'h03F6, 2, 1, 8'hFF);
    win_read("R8 other address full", 16'h01F7, 2, 1, 8'hFF);
    win_read("R9 memory window full", 16'h03F7, 2, 0, 8'hFF);
    @(negedge clk);
    host_addr = 16'h03F7; win_num = 2; win_is_io = 1; win_hit = 0; host_ior = 1;
    #1 check("R10 no hit no drive", data_oe, 8'h00);
    host_ior = 0; win_hit = 1; host_iow = 1; host_wdata = 8'h55;
    #1 check("R10 write no drive", data_oe, 8'h00);
    @(negedge clk);
    host_iow = 0; win_hit = 0; host_addr = '0;
    set_mode(2, 2'b00);
  endtask

  task automatic t_independent;
    set_mode(1, 2'b01);
    set_mode(3, 2'b10);
    win_read("R11 window 1", 16'h03F7, 1, 1, 8'h7F);
    win_read("R11 window 3", 16'h03F7, 3, 1, 8'h80);
    win_read("R11 window 0 untouched", 16'h03F7, 0, 1, 8'hFF);
    win_read("R11 window 2 untouched", 16'h0377, 2, 1, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_modes();
    t_other();
    t_independent();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule